// File: doc/BRIEF.md
# Synchronous Decade Frequency Divider

This block turns a reference clock into a family of timing outputs: a 10 kHz square wave, then one output per decade below it (1 kHz, 100 Hz, 10 Hz, 1 Hz with the default four decades), and a separate once-per-second pulse 100 ms wide. A free-running base-tick counter splits the reference into fixed intervals of 50 µs (or 100 µs when a 5 MHz reference is used). Each base tick advances a chain of digit counters. The lowest digit is a divide-by-two that can be switched off. Each higher digit is a decimal counter fed by the carry of the digit below it.

Every output is a registered decode of a digit value, loaded on the tick boundary. Because of this, all rising edges fall on one clock edge and the outputs behave like one synchronous counter chain. The 10 kHz output also has a mid-tick clear, placed at a fixed clock offset, which sets its duty cycle.

Two choices are fixed at elaboration: a 26 MHz reference (longer tick) and square-wave (50%) outputs instead of 20% outputs. A rate-select input chooses between the 10 MHz and 5 MHz references. An external arm/sync controller drives the hold input. Hold resets the chain, and releasing it starts the chain in phase with an outside event.

Top module: `refdiv_chain`

## Requirements
- R1: While `rst` or `hold_i` is high, every digit is zero and all of `sq_o` and `pps_o` are high. After the last cycle with hold high, the base tick starts from phase 0, so the first tick after release has all digits at zero.
- R2: A base tick lasts `TICK_STD` clocks (500 by default) when `FAST_REF`=0 and `TICK_FAST` clocks (1300 by default) when `FAST_REF`=1. Outputs change only on tick boundaries, except for the mid-tick clear of `sq_o[0]`.
- R3: With `rate_sel_i`=0 (10 MHz reference), the lowest digit alternates 0,1 on each tick and carries when it wraps, so `sq_o[0]` has a period of 2 ticks. With `rate_sel_i`=1 (5 MHz reference), the lowest digit stays 0 and carries on every tick, so `sq_o[0]` has a period of 1 tick.
- R4: `rate_sel_i` is sampled only at the clock edge that ends a tick, and that value governs the coming tick. Changes between those edges have no effect. When `FAST_REF`=1 the input is ignored and the 10 MHz behaviour applies.
- R5: Decade digits 1..`NUM_DEC` each count 0..9 and wrap to 0. A digit advances only on a tick in which the digit below it wraps, so each output's period is ten times the period of the output below it.
- R6: For k ≥ 1, `sq_o[k]` is high while digit k is below 2 when `SQUARE`=0, and below 5 when `SQUARE`=1.
- R7: `pps_o` is high exactly while the top digit equals 0, and it rises on the tick after the top digit wraps.
- R8: When `SQUARE`=0, `sq_o[0]` goes high at the start of a tick in which digit 0 is 0. It is cleared after 2/5 of a tick (200 clocks at 10 MHz, 520 clocks at 26 MHz), or after 1/5 of a tick (100 clocks) with `rate_sel_i`=1.
- R9: When `SQUARE`=1, `sq_o[0]` equals (digit 0 == 0) for a whole tick at the 10 MHz and 26 MHz settings. With `rate_sel_i`=1 it is cleared after half a tick rounded down to a multiple of 4 clocks (248 clocks by default).
- R10: Every rising edge of `sq_o[NUM_DEC:1]` and `pps_o` occurs on the clock edge that starts a tick, which is the same edge on which `sq_o[0]` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_i | input | 1 | Holds the chain cleared with all outputs high; release starts tick phase 0 |
| rate_sel_i | input | 1 | 0 = 10 MHz reference, 1 = 5 MHz reference; ignored when FAST_REF=1 |
| sq_o | output | NUM_DEC+1 | Bit 0 is the 10 kHz output; bit k is the output of decade k |
| pps_o | output | 1 | Pulse that is high while the top digit is zero |

## Verification
The hardest case to reach from the ports is a rate-select change that lands exactly on a tick boundary. Only the value present at the edge that ends the tick may count. A wrong design would either react to changes in mid-tick or lag by one tick. The stimulus raises `rate_sel_i` in mid-tick, where it must be ignored. It then raises the input for just the one cycle that covers a tick-ending edge, and checks that only that one tick runs at the 5 MHz setting: the lowest digit skips a count and the 10 kHz clear moves to the earlier offset. Reaching the top-digit wrap and the point where all outputs rise together takes the full output cycle, so the bench shortens the tick and uses three decades.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    // Reference rate chosen by the rate-select input.
    typedef enum logic {
        RATE_FULL = 1'b0,   // 10 MHz reference: lowest stage divides by two
        RATE_HALF = 1'b1    // 5 MHz reference: lowest stage bypassed
    } rate_e;

    typedef logic [3:0] digit_t;

    // Clock offset inside a tick at which the lowest output is cleared.
    // A return value equal to the tick length means no clear.
    function automatic int clr_offset(int tick, bit square, bit half);
        int v;
        if (square) v = half ? ((tick / 2) / 4) * 4 : tick;
        else        v = half ? tick / 5 : (2 * tick) / 5;
        if (v < 1) v = 1;
        return v;
    endfunction

endpackage

// File: rtl/refdiv_tick.sv
module refdiv_tick
    import refdiv_pkg::*;
#(
    parameter int TICK     = 500,
    parameter int CW       = 9,
    parameter bit FAST_REF = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold_i,
    input  logic          rate_sel_i,
    output logic [CW-1:0] tcnt,
    output logic          tick_end,
    output rate_e         rate_now,
    output rate_e         rate_q
);
    localparam logic [CW-1:0] LAST = CW'(TICK - 1);

    assign rate_now = FAST_REF ? RATE_FULL : rate_e'(rate_sel_i);
    assign tick_end = (tcnt == LAST) && !hold_i;

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            tcnt   <= '0;
            rate_q <= rate_now;
        end else if (tick_end) begin
            tcnt   <= '0;
            rate_q <= rate_now;
        end else begin
            tcnt   <= tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/refdiv_decade.sv
module refdiv_decade
    import refdiv_pkg::*;
#(
    parameter int MODULUS = 10
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clear_i,
    input  logic   step_i,
    input  logic   force_wrap_i,
    output digit_t nxt_o,
    output logic   roll_o
);
    localparam digit_t TOP = digit_t'(MODULUS - 1);

    digit_t cur;

    assign roll_o = step_i && (force_wrap_i || cur == TOP);

    always_comb begin
        if (roll_o)      nxt_o = '0;
        else if (step_i) nxt_o = cur + 4'd1;
        else             nxt_o = cur;
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) cur <= '0;
        else                cur <= nxt_o;
    end
endmodule

// File: rtl/refdiv_shaper.sv
module refdiv_shaper
    import refdiv_pkg::*;
#(
    parameter int NUM_DEC = 4,
    parameter int CW      = 9,
    parameter bit SQUARE  = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hold_i,
    input  logic                 tick_end,
    input  digit_t [NUM_DEC:0]   dig_nxt,
    input  logic [CW-1:0]        tcnt,
    input  logic [CW-1:0]        clr_at,
    output logic [NUM_DEC:0]     sq_o,
    output logic                 pps_o
);
    localparam digit_t THR = SQUARE ? 4'd5 : 4'd2;

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            sq_o  <= '1;
            pps_o <= 1'b1;
        end else if (tick_end) begin
            sq_o[0] <= (dig_nxt[0] == '0);
            for (int k = 1; k <= NUM_DEC; k++) begin
                sq_o[k] <= (dig_nxt[k] < THR);
            end
            pps_o <= (dig_nxt[NUM_DEC] == '0);
        end else if (tcnt == clr_at) begin
            sq_o[0] <= 1'b0;
        end
    end
endmodule

// File: rtl/refdiv_chain.sv
module refdiv_chain
    import refdiv_pkg::*;
#(
    parameter bit FAST_REF  = 1'b0,
    parameter bit SQUARE    = 1'b0,
    parameter int TICK_STD  = 500,
    parameter int TICK_FAST = 1300,
    parameter int NUM_DEC   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_i,
    input  logic             rate_sel_i,
    output logic [NUM_DEC:0] sq_o,
    output logic             pps_o
);
    localparam int TICK     = FAST_REF ? TICK_FAST : TICK_STD;
    localparam int CW       = (TICK > 1) ? $clog2(TICK) : 1;
    localparam int OFS_FULL = clr_offset(TICK, SQUARE, 1'b0);
    localparam int OFS_HALF = clr_offset(TICK, SQUARE, 1'b1);
    localparam logic [CW-1:0] AT_FULL = CW'(OFS_FULL - 1);
    localparam logic [CW-1:0] AT_HALF = CW'(OFS_HALF - 1);

    logic [CW-1:0]      tcnt;
    logic [CW-1:0]      clr_at;
    logic               tick_end;
    rate_e              rate_now;
    rate_e              rate_q;
    digit_t [NUM_DEC:0] dig_nxt;
    logic [NUM_DEC+1:0] carry;

    refdiv_tick #(.TICK(TICK), .CW(CW), .FAST_REF(FAST_REF)) tick_i (
        .clk(clk), .rst(rst), .hold_i(hold_i), .rate_sel_i(rate_sel_i),
        .tcnt(tcnt), .tick_end(tick_end), .rate_now(rate_now), .rate_q(rate_q)
    );

    assign clr_at   = (rate_q == RATE_HALF) ? AT_HALF : AT_FULL;
    assign carry[0] = tick_end;

    generate
        for (genvar s = 0; s <= NUM_DEC; s++) begin : g_stage
            if (s == 0) begin : g_low
                refdiv_decade #(.MODULUS(2)) dec_i (
                    .clk(clk), .rst(rst), .clear_i(hold_i), .step_i(carry[0]),
                    .force_wrap_i(rate_now == RATE_HALF),
                    .nxt_o(dig_nxt[0]), .roll_o(carry[1])
                );
            end else begin : g_dec
                refdiv_decade #(.MODULUS(10)) dec_i (
                    .clk(clk), .rst(rst), .clear_i(hold_i), .step_i(carry[s]),
                    .force_wrap_i(1'b0),
                    .nxt_o(dig_nxt[s]), .roll_o(carry[s+1])
                );
            end
        end
    endgenerate

    refdiv_shaper #(.NUM_DEC(NUM_DEC), .CW(CW), .SQUARE(SQUARE)) shape_i (
        .clk(clk), .rst(rst), .hold_i(hold_i), .tick_end(tick_end),
        .dig_nxt(dig_nxt), .tcnt(tcnt), .clr_at(clr_at),
        .sq_o(sq_o), .pps_o(pps_o)
    );
endmodule

// File: rtl/refdiv_chain_chk.sv
module refdiv_chain_chk #(
    parameter int NUM_DEC = 4,
    parameter int CW      = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             hold_i,
    input logic [CW-1:0]    tcnt,
    input logic [CW-1:0]    clr_at,
    input logic             top_roll,
    input logic [NUM_DEC:0] sq_o,
    input logic             pps_o
);
    p_hold_forces_high_r1: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> ((&sq_o) && pps_o && tcnt == '0));

    p_pps_inside_top_r7: assert property (@(posedge clk) disable iff (rst)
        pps_o |-> sq_o[NUM_DEC]);

    p_pps_after_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        top_roll |=> pps_o);

    p_rise_on_tick_r10: assert property (@(posedge clk) disable iff (rst)
        ((|(sq_o[NUM_DEC:1] & ~$past(sq_o[NUM_DEC:1]))) || $rose(pps_o))
        |-> (tcnt == '0));

    p_low_fall_at_offset_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(sq_o[0]) |-> (tcnt == clr_at + 1'b1 || tcnt == '0));
endmodule

bind refdiv_chain refdiv_chain_chk #(.NUM_DEC(NUM_DEC), .CW(CW)) chk_i (
    .clk(clk), .rst(rst), .hold_i(hold_i), .tcnt(tcnt), .clr_at(clr_at),
    .top_roll(carry[NUM_DEC+1]), .sq_o(sq_o), .pps_o(pps_o)
);

// File: tb/refdiv_chain_tb.sv
module refdiv_chain_tb_top;
    localparam int T_STD  = 10;
    localparam int T_FAST = 26;
    localparam int ND     = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold = 1'b1;
    logic fsel = 1'b0;
    logic [ND:0] sq_a, sq_b, sq_c;
    logic pps_a, pps_b, pps_c;
    int tests = 0;
    int fails = 0;
    int cur = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // 20% outputs, standard tick
    refdiv_chain #(.FAST_REF(1'b0), .SQUARE(1'b0), .TICK_STD(T_STD), .TICK_FAST(T_FAST), .NUM_DEC(ND))
        dut_i (.clk(clk), .rst(rst), .hold_i(hold), .rate_sel_i(fsel), .sq_o(sq_a), .pps_o(pps_a));
    // 50% outputs, standard tick
    refdiv_chain #(.FAST_REF(1'b0), .SQUARE(1'b1), .TICK_STD(T_STD), .TICK_FAST(T_FAST), .NUM_DEC(ND))
        dut_sq_i (.clk(clk), .rst(rst), .hold_i(hold), .rate_sel_i(fsel), .sq_o(sq_b), .pps_o(pps_b));
    // 20% outputs, 26 MHz tick
    refdiv_chain #(.FAST_REF(1'b1), .SQUARE(1'b0), .TICK_STD(T_STD), .TICK_FAST(T_FAST), .NUM_DEC(ND))
        dut_fast_i (.clk(clk), .rst(rst), .hold_i(hold), .rate_sel_i(fsel), .sq_o(sq_c), .pps_o(pps_c));

    // Expected {pps, sq[3:0]} k clocks after release, from the requirements.
    function automatic logic [4:0] model(int t, bit fast, bit sq, bit half, int k);
        int n, ph, d0, d1, d2, d3, ofs, thr;
        bit hr;
        logic [4:0] v;
        hr = half && !fast;
        n  = k / t;
        ph = k % t;
        if (hr) begin
            d0 = 0; d1 = n % 10; d2 = (n / 10) % 10; d3 = (n / 100) % 10;
        end else begin
            d0 = n % 2; d1 = (n / 2) % 10; d2 = (n / 20) % 10; d3 = (n / 200) % 10;
        end
        if (sq) ofs = hr ? ((t / 2) / 4) * 4 : t;
        else    ofs = hr ? t / 5 : (2 * t) / 5;
        thr  = sq ? 5 : 2;
        v[0] = (d0 == 0) && (ph < ofs);
        v[1] = d1 < thr;
        v[2] = d2 < thr;
        v[3] = d3 < thr;
        v[4] = (d3 == 0);
        return v;
    endfunction

    task automatic check(string req, string what, logic [4:0] got, logic [4:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic wait_to(int k);
        repeat (k - cur) @(posedge clk);
        #1;
        cur = k;
    endtask

    task automatic start_run(logic f);
        hold = 1'b1;
        fsel = f;
        @(posedge clk);
        @(posedge clk);
        #1;
        hold = 1'b0;
        cur  = 0;
    endtask

    task automatic t_reset;
        @(posedge clk); @(posedge clk); #1;
        check("R1", "reset dut_i", {pps_a, sq_a}, 5'b11111);
        check("R1", "reset dut_sq_i", {pps_b, sq_b}, 5'b11111);
        check("R1", "reset dut_fast_i", {pps_c, sq_c}, 5'b11111);
        rst = 1'b0;
    endtask

    task automatic t_full_rate;
        int pts[11] = '{3, 4, 10, 20, 40, 200, 400, 2000, 4000, 19999, 20000};
        start_run(1'b0);
        foreach (pts[i]) begin
            wait_to(pts[i]);
            check("R2 R3 R5 R6 R7 R8", $sformatf("10M 20%% k=%0d", pts[i]),
                  {pps_a, sq_a}, model(T_STD, 0, 0, 0, pts[i]));
        end
        // R10: every output rose together at k=20000 after all were low at 19999
    endtask

    task automatic t_half_rate;
        int pts[6] = '{1, 2, 10, 20, 100, 200};
        start_run(1'b1);
        foreach (pts[i]) begin
            wait_to(pts[i]);
            check("R3 R8", $sformatf("5M 20%% k=%0d", pts[i]),
                  {pps_a, sq_a}, model(T_STD, 0, 0, 1, pts[i]));
        end
    endtask

    task automatic t_sample_point;
        start_run(1'b0);
        fsel = 1'b1;                 // mid-tick: must be ignored
        wait_to(3);
        check("R4", "mid-tick select ignored k=3", {pps_a, sq_a}, 5'b11111);
        fsel = 1'b0;
        wait_to(9);
        fsel = 1'b1;                 // present only at the tick-ending edge 10
        wait_to(10);
        fsel = 1'b0;
        wait_to(11);
        check("R4", "boundary sample, lowest digit held k=11", {pps_a, sq_a}, 5'b11111);
        wait_to(12);
        check("R4", "boundary sample, 1/5 clear k=12", {pps_a, sq_a}, 5'b11110);
        wait_to(31);
        check("R4", "back to 10M k=31", {pps_a, sq_a}, 5'b11101);
    endtask

    task automatic t_fast;
        int pts[6] = '{9, 10, 26, 52, 103, 104};
        start_run(1'b1);             // select must be ignored in 26 MHz mode
        foreach (pts[i]) begin
            wait_to(pts[i]);
            check("R2 R4 R8", $sformatf("26M k=%0d", pts[i]),
                  {pps_c, sq_c}, model(T_FAST, 1, 0, 0, pts[i]));
        end
    endtask

    task automatic t_square;
        int pa[4] = '{9, 10, 80, 100};
        int pb[4] = '{3, 4, 40, 50};
        start_run(1'b0);
        foreach (pa[i]) begin
            wait_to(pa[i]);
            check("R6 R9", $sformatf("10M 50%% k=%0d", pa[i]),
                  {pps_b, sq_b}, model(T_STD, 0, 1, 0, pa[i]));
        end
        start_run(1'b1);
        foreach (pb[i]) begin
            wait_to(pb[i]);
            check("R6 R9", $sformatf("5M 50%% k=%0d", pb[i]),
                  {pps_b, sq_b}, model(T_STD, 0, 1, 1, pb[i]));
        end
    endtask

    task automatic t_hold_mid;
        start_run(1'b0);
        wait_to(55);
        check("R1", "running before hold k=55", {pps_a, sq_a}, 5'b11100);
        hold = 1'b1;
        @(posedge clk); #1;
        check("R1", "hold drives all high", {pps_a, sq_a}, 5'b11111);
        start_run(1'b0);
        wait_to(4);
        check("R1", "restart from zero k=4", {pps_a, sq_a}, 5'b11110);
        wait_to(20);
        check("R1", "digits cleared by hold k=20", {pps_a, sq_a}, 5'b11111);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        t_reset();
        t_full_rate();
        t_half_rate();
        t_sample_point();
        t_fast();
        t_square();
        t_hold_mid();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule